// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link in front of a small byte-wide memory. The serial clock, active-low select, serial data input and active-low pause input all arrive asynchronously. Each one passes through a synchroniser into the fast system clock, and the block detects serial clock and select edges there. Transfers use clock mode 0. Input bits are taken on the rising serial clock edge and the output bit changes on the falling edge, most significant bit first. After select falls, the first byte is a command. Depending on that command, the block raises a one-cycle strobe towards a separate status-register block, or it streams the status byte back, or it hands the next byte to the status block. For array commands it first collects a 16-bit address and then streams bytes out of the internal array or writes received bytes into it. In both cases the address moves on after each byte and wraps within the array.

The controller is one state machine. IDLE is left only on a falling select edge, which always enters OPCODE. OPCODE moves on after its eighth bit to one of these states:
- ADDR for an array read, or for an array write while the write-enable input is high.
- RD_STAT for a status read.
- WR_STAT for a status write.
- DONE for the two latch commands, and for an array write while write-enable is low.
- LOCKED for any other byte.

ADDR moves on after sixteen bits, to RD_DATA for a read or to WR_DATA for a write. WR_STAT moves to DONE after one byte. RD_DATA, WR_DATA and RD_STAT loop on themselves byte after byte. Select going high returns every state to IDLE. A falling select edge restarts the sequence in OPCODE from any state.

Top module: `spi_mem_front`

## Requirements
- R1: A sequence begins only on a falling edge of select; all bits move most significant bit first. A select that rises part-way through a command or address discards the partial sequence, and the next selection decodes a fresh command.
- R2: Command byte 0000x110 raises `wren_set_o` for one cycle, and 0000x100 raises `wren_clr_o` for one cycle; bit 3 of any command byte is ignored.
- R3: Command 0000x101 drives `stat_rd_i` out on the serial output, most significant bit first, and repeats the same byte for as long as clocking continues.
- R4: Command 0000x001 takes the next byte and raises `stat_wr_o` for one cycle with that byte on `stat_wr_data_o`.
- R5: Command 0000x011 followed by a 16-bit address streams bytes from the array starting at index (address mod MEM_DEPTH). The index increments after every byte and wraps from MEM_DEPTH-1 to 0.
- R6: Command 0000x010 with `wel_i` high, followed by an address, stores every completed data byte in the array. Each stored byte is also reported as a one-cycle `wr_stb_o` with `wr_addr_o` and `wr_data_o`. The address advances after each byte, and its low log2(MEM_DEPTH) bits wrap.
- R7: Command 0000x010 while `wel_i` is low produces no write strobe and leaves the array unchanged.
- R8: Data bits of an incomplete byte, cut short by select rising, are never committed.
- R9: A command byte with a non-zero upper nibble, or with low three bits 000 or 111, raises no strobes for the rest of that selection and keeps the output enable low until the next falling select edge.
- R10: While select is high the output enable is low, and serial clock or data activity causes no strobes.
- R11: While selected, a low pause input that is sampled while the serial clock is low freezes the transfer. During the freeze the output enable is low and clock and data are ignored. A high pause input sampled while the serial clock is low resumes the transfer with its bit position and shift contents intact.
- R12: The four strobes are single-cycle pulses, and no two are active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the master, asynchronous |
| csn_in | input | 1 | Active-low select, asynchronous |
| mosi_in | input | 1 | Serial data into the block |
| holdn_in | input | 1 | Active-low pause request |
| stat_rd_i | input | 8 | Current status byte from the status block |
| wel_i | input | 1 | Write-enable latch state from the status block |
| miso_o | output | 1 | Serial data out, valid while `miso_oe_o` is high |
| miso_oe_o | output | 1 | Output enable; low means high impedance |
| wren_set_o | output | 1 | Pulse: set the write-enable latch |
| wren_clr_o | output | 1 | Pulse: clear the write-enable latch |
| stat_wr_o | output | 1 | Pulse: write status byte |
| stat_wr_data_o | output | 8 | Byte for the status write |
| wr_stb_o | output | 1 | Pulse: one array byte committed |
| wr_addr_o | output | 16 | Address of the committed byte |
| wr_data_o | output | 8 | Value of the committed byte |

## Verification
The bench builds the block with MEM_DEPTH of 64 and two synchroniser stages. Its serial clock runs at one sixteenth of the system clock, so every edge clears the synchronisers with margin. The shallow array puts the index wrap within a two-byte transfer from address 0x003F. It also lets an address of 0x0050 alias onto index 0x10, which shows that only the low index bits choose the cell. The pause scenarios stop a transfer in the middle of a command byte and again in the middle of a read byte, then toggle clock and data during the stop.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_RD_DATA,
        S_WR_DATA,
        S_RD_STAT,
        S_WR_STAT,
        S_DONE,
        S_LOCKED
    } fe_state_t;

    // low three bits of a command byte; upper nibble must be zero, bit 3 ignored
    localparam logic [2:0] OP_WEN_SET  = 3'b110;
    localparam logic [2:0] OP_WEN_CLR  = 3'b100;
    localparam logic [2:0] OP_STAT_RD  = 3'b101;
    localparam logic [2:0] OP_STAT_WR  = 3'b001;
    localparam logic [2:0] OP_ARR_RD   = 3'b011;
    localparam logic [2:0] OP_ARR_WR   = 3'b010;

    function automatic fe_state_t decode_op(input logic [7:0] op, input logic wel);
        fe_state_t nxt;
        if (op[7:4] != 4'h0) begin
            nxt = S_LOCKED;
        end else begin
            case (op[2:0])
                OP_WEN_SET, OP_WEN_CLR: nxt = S_DONE;
                OP_STAT_RD:             nxt = S_RD_STAT;
                OP_STAT_WR:             nxt = S_WR_STAT;
                OP_ARR_RD:              nxt = S_ADDR;
                OP_ARR_WR:              nxt = wel ? S_ADDR : S_DONE;
                default:                nxt = S_LOCKED;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign level_o = chain[STAGES-1];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[widx_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[ridx_i];

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_mem_pkg::*;
#(
    parameter int MEM_DEPTH   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_in,
    input  logic        csn_in,
    input  logic        mosi_in,
    input  logic        holdn_in,
    input  logic [7:0]  stat_rd_i,
    input  logic        wel_i,
    output logic        miso_o,
    output logic        miso_oe_o,
    output logic        wren_set_o,
    output logic        wren_clr_o,
    output logic        stat_wr_o,
    output logic [7:0]  stat_wr_data_o,
    output logic        wr_stb_o,
    output logic [15:0] wr_addr_o,
    output logic [7:0]  wr_data_o
);

    localparam int          ADDR_W = 16;
    localparam int          IDX_W  = $clog2(MEM_DEPTH);
    localparam logic [15:0] AMASK  = 16'(MEM_DEPTH - 1);

    // synchronised inputs: {hold, mosi, cs, sclk}
    logic [3:0] sync_lvl;
    spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .INIT(4'b1010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({holdn_in, mosi_in, csn_in, sclk_in}),
        .level_o (sync_lvl)
    );

    logic sclk_lvl, cs_lvl, mosi_lvl, hold_lvl;
    logic sclk_q, cs_q;
    assign sclk_lvl = sync_lvl[0];
    assign cs_lvl   = sync_lvl[1];
    assign mosi_lvl = sync_lvl[2];
    assign hold_lvl = sync_lvl[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_lvl;
            cs_q   <= cs_lvl;
        end
    end

    logic cs_fall, paused, act_r, act_f;
    assign cs_fall = cs_q && !cs_lvl;

    // pause tracking: changes only while serial clock is low and selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               paused <= 1'b0;
        else if (cs_lvl)                          paused <= 1'b0;
        else if (!paused && !hold_lvl && !sclk_lvl) paused <= 1'b1;
        else if (paused && hold_lvl && !sclk_lvl)   paused <= 1'b0;
    end

    assign act_r = sclk_lvl && !sclk_q && !paused && !cs_lvl;
    assign act_f = !sclk_lvl && sclk_q && !paused && !cs_lvl;

    fe_state_t           st, st_n;
    logic [3:0]          bitcnt;
    logic [7:0]          in_sh, in_next, out_sh;
    logic [ADDR_W-1:0]   addr, addr_inc;
    logic                rd_mode, byte_done, addr_done, mem_we;
    logic [7:0]          mem_rdata;

    assign in_next   = {in_sh[6:0], mosi_lvl};
    assign byte_done = (bitcnt[2:0] == 3'd7);
    assign addr_done = (bitcnt == 4'd15);
    assign addr_inc  = (addr & ~AMASK) | ((addr + 16'd1) & AMASK);
    assign mem_we    = act_r && (st == S_WR_DATA) && byte_done;

    spi_mem_array #(.DEPTH(MEM_DEPTH), .DATA_W(8)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .widx_i  (addr[IDX_W-1:0]),
        .wdata_i (in_next),
        .ridx_i  (addr[IDX_W-1:0]),
        .rdata_o (mem_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (cs_lvl) begin
            st_n = S_IDLE;
        end else if (cs_fall) begin
            st_n = S_OPCODE;
        end else if (act_r) begin
            unique case (st)
                S_OPCODE:  if (byte_done) st_n = decode_op(in_next, wel_i);
                S_ADDR:    if (addr_done) st_n = rd_mode ? S_RD_DATA : S_WR_DATA;
                S_WR_STAT: if (byte_done) st_n = S_DONE;
                default:   st_n = st;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt         <= '0;
            in_sh          <= '0;
            out_sh         <= '0;
            addr           <= '0;
            rd_mode        <= 1'b0;
            wren_set_o     <= 1'b0;
            wren_clr_o     <= 1'b0;
            stat_wr_o      <= 1'b0;
            stat_wr_data_o <= '0;
            wr_stb_o       <= 1'b0;
            wr_addr_o      <= '0;
            wr_data_o      <= '0;
        end else begin
            wren_set_o <= 1'b0;
            wren_clr_o <= 1'b0;
            stat_wr_o  <= 1'b0;
            wr_stb_o   <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
            end else if (act_r) begin
                in_sh  <= in_next;
                bitcnt <= (st == S_ADDR || !byte_done) ? bitcnt + 4'd1 : 4'd0;
                unique case (st)
                    S_OPCODE: if (byte_done && in_next[7:4] == 4'h0) begin
                        wren_set_o <= (in_next[2:0] == OP_WEN_SET);
                        wren_clr_o <= (in_next[2:0] == OP_WEN_CLR);
                        rd_mode    <= (in_next[2:0] == OP_ARR_RD);
                    end
                    S_ADDR:    addr <= {addr[ADDR_W-2:0], mosi_lvl};
                    S_WR_DATA: if (byte_done) begin
                        wr_stb_o  <= 1'b1;
                        wr_addr_o <= addr;
                        wr_data_o <= in_next;
                        addr      <= addr_inc;
                    end
                    S_RD_DATA: if (byte_done) addr <= addr_inc;
                    S_WR_STAT: if (byte_done) begin
                        stat_wr_o      <= 1'b1;
                        stat_wr_data_o <= in_next;
                    end
                    default: ;
                endcase
            end else if (act_f && (st == S_RD_DATA || st == S_RD_STAT)) begin
                if (bitcnt[2:0] == 3'd0)
                    out_sh <= (st == S_RD_DATA) ? mem_rdata : stat_rd_i;
                else
                    out_sh <= {out_sh[6:0], 1'b0};
            end
        end
    end

    assign miso_o    = out_sh[7];
    assign miso_oe_o = !cs_lvl && !paused && (st == S_RD_DATA || st == S_RD_STAT);

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk
    import spi_mem_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_lvl,
    input logic      paused,
    input logic      miso_oe_o,
    input logic      wren_set_o,
    input logic      wren_clr_o,
    input logic      stat_wr_o,
    input logic      wr_stb_o,
    input fe_state_t st,
    input logic [3:0] bitcnt,
    input logic [7:0] in_sh
);

    // R10
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |-> !miso_oe_o);

    // R11
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !miso_oe_o);

    // R11
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> ($stable(bitcnt) && $stable(in_sh)));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_set_o, wren_clr_o, stat_wr_o, wr_stb_o}));

    // R12
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R9
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOCKED) |-> (!miso_oe_o && !wr_stb_o && !wren_set_o && !wren_clr_o && !stat_wr_o));

    // R9
    locked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOCKED && !cs_lvl) |=> (st == S_LOCKED));

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (.*);

// File: tb/test_spi_mem_front.sv
module test_spi_mem_front;

    localparam int DEPTH = 64;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, holdn = 1'b1;
    logic [7:0] stat_rd = 8'hA5;
    logic wel = 1'b0;

    logic        miso_o, miso_oe_o, wren_set_o, wren_clr_o, stat_wr_o, wr_stb_o;
    logic [7:0]  stat_wr_data_o, wr_data_o;
    logic [15:0] wr_addr_o;

    spi_mem_front #(.MEM_DEPTH(DEPTH), .SYNC_STAGES(2)) i_spi_mem_front (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .csn_in(csn), .mosi_in(mosi),
        .holdn_in(holdn), .stat_rd_i(stat_rd), .wel_i(wel),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o),
        .wren_set_o(wren_set_o), .wren_clr_o(wren_clr_o),
        .stat_wr_o(stat_wr_o), .stat_wr_data_o(stat_wr_data_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int n_set = 0, n_clr = 0, n_swr = 0, n_wr = 0;
    logic [7:0]  last_swr = '0, last_wdata = '0;
    logic [15:0] last_waddr = '0;
    bit oe_any = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wren_set_o) n_set++;
            if (wren_clr_o) n_clr++;
            if (stat_wr_o) begin n_swr++; last_swr = stat_wr_data_o; end
            if (wr_stb_o) begin n_wr++; last_waddr = wr_addr_o; last_wdata = wr_data_o; end
            if (miso_oe_o) oe_any = 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic bits(input int n, input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            mosi = tx[7-i];
            wait_clk(HALF);
            rx = {rx[6:0], miso_o};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        bits(8, tx, rx);
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        xb(op, d);
        xb(a[15:8], d);
        xb(a[7:0], d);
    endtask

    task automatic t_reset();
        chk("R10", "oe after reset", miso_oe_o, 0);
        chk("R12", "strobes after reset", n_set + n_clr + n_swr + n_wr, 0);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        sel(); xb(8'h06, d); desel();
        chk("R2", "set count", n_set, 1);
        sel(); xb(8'h0E, d); desel();
        chk("R2", "set count bit3", n_set, 2);
        sel(); xb(8'h04, d); desel();
        chk("R2", "clr count", n_clr, 1);
        chk("R12", "no other strobes", n_swr + n_wr, 0);
    endtask

    task automatic t_stat_rd();
        logic [7:0] d, r1, r2;
        oe_any = 0;
        sel(); xb(8'h05, d); xb(8'h00, r1); xb(8'h00, r2); desel();
        chk("R3", "status byte 1", r1, 8'hA5);
        chk("R3", "status byte 2", r2, 8'hA5);
        chk("R3", "oe during status", oe_any, 1);
    endtask

    task automatic t_stat_wr();
        logic [7:0] d;
        sel(); xb(8'h01, d); xb(8'h3C, d); desel();
        chk("R4", "status write count", n_swr, 1);
        chk("R4", "status write data", last_swr, 8'h3C);
    endtask

    task automatic t_write_read();
        logic [7:0] d, r1, r2, r3;
        int base = n_wr;
        wel = 1'b1;
        sel(); cmd_addr(8'h02, 16'h0010); xb(8'h11, d); xb(8'h22, d); xb(8'h33, d); desel();
        chk("R6", "write count", n_wr - base, 3);
        chk("R6", "last addr", last_waddr, 16'h0012);
        chk("R6", "last data", last_wdata, 8'h33);
        sel(); cmd_addr(8'h03, 16'h0010); xb(0, r1); xb(0, r2); xb(0, r3); desel();
        chk("R5", "read 0x10", r1, 8'h11);
        chk("R5", "read 0x11", r2, 8'h22);
        chk("R1", "read 0x12 msb first", r3, 8'h33);
    endtask

    task automatic t_wrap();
        logic [7:0] d, r1, r2;
        sel(); cmd_addr(8'h02, 16'h003F); xb(8'h77, d); xb(8'h88, d); desel();
        chk("R6", "wrapped write addr", last_waddr, 16'h0000);
        sel(); cmd_addr(8'h0B, 16'h003F); xb(0, r1); xb(0, r2); desel();
        chk("R5", "read top", r1, 8'h77);
        chk("R5", "read wrapped", r2, 8'h88);
        sel(); cmd_addr(8'h03, 16'h0050); xb(0, r1); desel();
        chk("R5", "alias 0x50", r1, 8'h11);
    endtask

    task automatic t_no_wel();
        logic [7:0] d, r1;
        int base = n_wr;
        wel = 1'b0;
        sel(); cmd_addr(8'h02, 16'h0010); xb(8'h99, d); desel();
        chk("R7", "no write strobe", n_wr - base, 0);
        sel(); cmd_addr(8'h03, 16'h0010); xb(0, r1); desel();
        chk("R7", "cell unchanged", r1, 8'h11);
    endtask

    task automatic t_partial();
        logic [7:0] d, r1, r2;
        int base = n_wr;
        wel = 1'b1;
        sel(); cmd_addr(8'h02, 16'h0012); xb(8'h44, d); bits(5, 8'hAA, d); desel();
        chk("R8", "one committed byte", n_wr - base, 1);
        sel(); cmd_addr(8'h03, 16'h0012); xb(0, r1); xb(0, r2); desel();
        chk("R8", "full byte stored", r1, 8'h44);
        chk("R8", "partial not stored", r2, 8'h00);
    endtask

    task automatic t_invalid();
        logic [7:0] d;
        int bs = n_set, bw = n_swr;
        oe_any = 0;
        sel(); xb(8'h16, d); xb(8'h06, d); xb(8'h05, d); desel();
        chk("R9", "no set after bad op", n_set - bs, 0);
        chk("R9", "oe stays low", oe_any, 0);
        sel(); xb(8'h07, d); xb(8'h01, d); xb(8'h55, d); desel();
        chk("R9", "no status write after bad op", n_swr - bw, 0);
        sel(); xb(8'h06, d); desel();
        chk("R9", "recovers on next select", n_set - bs, 1);
    endtask

    task automatic t_cs_idle();
        logic [7:0] d;
        int bs = n_set, bw = n_wr;
        oe_any = 0;
        bits(8, 8'h06, d);
        bits(8, 8'h02, d);
        wait_clk(2 * HALF);
        chk("R10", "no strobes deselected", (n_set - bs) + (n_wr - bw), 0);
        chk("R10", "oe low deselected", oe_any, 0);
    endtask

    task automatic t_hold_op();
        logic [7:0] d;
        int bs = n_set;
        sel();
        bits(4, 8'h00, d);
        holdn = 1'b0; wait_clk(HALF);
        bits(8, 8'hFF, d);
        holdn = 1'b1; wait_clk(HALF);
        bits(4, 8'h60, d);
        desel();
        chk("R11", "paused command completes", n_set - bs, 1);
    endtask

    task automatic t_hold_rd();
        logic [7:0] d, ra, rb, r2;
        sel(); cmd_addr(8'h03, 16'h0010);
        bits(3, 8'h00, ra);
        holdn = 1'b0; wait_clk(HALF);
        oe_any = 0;
        bits(6, 8'hFF, d);
        chk("R11", "oe low while paused", oe_any, 0);
        holdn = 1'b1; wait_clk(HALF);
        bits(5, 8'h00, rb);
        xb(0, r2);
        desel();
        chk("R11", "byte across pause", {ra[2:0], rb[4:0]}, 8'h11);
        chk("R11", "next byte after pause", r2, 8'h22);
    endtask

    task automatic t_abort();
        logic [7:0] d, r1;
        int bs = n_set;
        sel(); xb(8'h03, d); xb(8'h00, d); desel();
        sel(); xb(8'h06, d); desel();
        chk("R1", "fresh decode after abort", n_set - bs, 1);
        sel(); xb(8'h03, d); bits(4, 8'h00, d); desel();
        sel(); cmd_addr(8'h03, 16'h0011); xb(0, r1); desel();
        chk("R1", "read after aborted address", r1, 8'h22);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch();
        t_stat_rd();
        t_stat_wr();
        t_write_read();
        t_wrap();
        t_no_wel();
        t_partial();
        t_invalid();
        t_cs_idle();
        t_hold_op();
        t_hold_rd();
        t_abort();
        finished = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule